// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block decides, clock by clock, when the high-side and low-side switches of a synchronous buck half-bridge may be enabled. It takes a qualified PWM command (LOW, HIGH or a tri-state "park" code), an active-low skip-mode input, an active-low disable input and a supply-good flag. It also takes three sensed comparator flags: the low-side gate has discharged below about 1 V, the switch node has fallen below about 2.2 V, and the high-side gate-source voltage has dropped below about 1.2 V. From these it drives two registered enables, `gh_en` and `gl_en`.

Dead time adapts to the power stage. Turning on either switch first turns the other one off, then waits for the matching sense flag, then counts a programmable number of cycles. When the switch node never drops far enough, a backup counter started by the high-side gate flag still brings the low side on. A command change while a wait is pending cancels that wait and starts the sequence again from the new command. The analog comparators, drivers and bootstrap supply lie outside the block.

Top module: `deadtime_sequencer`

## Requirements
- R1: When `supply_ok` is low at a clock edge, both `gh_en` and `gl_en` are low after that edge.
- R2: When `dis_n` is low at a clock edge, both outputs are low after that edge, for every PWM command.
- R3: The PWM codes 2'b10 and 2'b11 both mean tri-state, and either one drives both outputs low after the edge. Code 2'b00 is LOW and 2'b01 is HIGH.
- R4: When the block is enabled and `skip_n` is high, a steady HIGH command settles to `gh_en`=1, `gl_en`=0, and a steady LOW command settles to `gh_en`=0, `gl_en`=1.
- R5: While `skip_n` is low, `gl_en` is low after every edge. `gh_en` still settles high for a steady HIGH command.
- R6: On a change to HIGH, the change edge (edge 1) clears `gl_en` and leaves `gh_en` low. `gh_en` cannot rise while `low_gate_below` is low. With `low_gate_below` held high, `gh_en` rises at edge `dead_on`+2.
- R7: On a change to LOW with `skip_n` high, edge 1 clears `gh_en`. With `sw_node_below` held high, `gl_en` rises at edge `dead_off`+2.
- R8: With `sw_node_below` held low and `hs_vgs_below` held high, a change to LOW raises `gl_en` at edge `timeout`+2. If both flags stay low, `gl_en` does not rise.
- R9: Leaving tri-state for LOW turns on the low side at edge `dead_off`+2. Leaving tri-state for HIGH turns on the high side at edge `dead_on`+2.
- R10: `gh_en` and `gl_en` are never high after the same edge.
- R11: A command change during a pending wait cancels the pending turn-on. The new command's sequence counts from its own change edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 2 | 00 LOW, 01 HIGH, 1x tri-state |
| skip_n | input | 1 | Active-low skip mode; low keeps the low side off |
| dis_n | input | 1 | Active-low disable |
| supply_ok | input | 1 | Supply-good flag |
| low_gate_below | input | 1 | Low-side gate sensed below ~1 V |
| sw_node_below | input | 1 | Switch node sensed below ~2.2 V |
| hs_vgs_below | input | 1 | High-side gate-source sensed below ~1.2 V |
| dead_on | input | CW | Dead-on wait in cycles |
| dead_off | input | CW | Dead-off wait in cycles |
| timeout | input | CW | Backup low-side wait in cycles; set above `dead_off` |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |

## Verification
Every forced-off condition (supply, disable, tri-state, skip on the low side) takes effect one edge after it is presented. The bench checks it at the first falling edge that follows. A turn-on is due at edge count+2 after the command change, so the bench counts falling edges from the change until the enable rises and compares that number with `dead_on`+2, `dead_off`+2 or `timeout`+2. Steady-state table entries are held for 30 cycles, which exceeds every programmed wait, before the outputs are read. Overlap of the two enables is watched on every falling edge throughout the run.

// File: rtl/deadtime_sequencer.sv
module deadtime_sequencer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pwm_cmd,
  input  logic          skip_n,
  input  logic          dis_n,
  input  logic          supply_ok,
  input  logic          low_gate_below,
  input  logic          sw_node_below,
  input  logic          hs_vgs_below,
  input  logic [CW-1:0] dead_on,
  input  logic [CW-1:0] dead_off,
  input  logic [CW-1:0] timeout,
  output logic          gh_en,
  output logic          gl_en
);
  localparam logic [1:0] CMD_LOW  = 2'b00;
  localparam logic [1:0] CMD_HIGH = 2'b01;
  localparam logic [1:0] CMD_PARK = 2'b10;

  logic [1:0]    prev_cmd;
  logic [CW-1:0] dcnt, tcnt;
  logic          gh_q, gl_q;

  wire is_hi   = (pwm_cmd == CMD_HIGH);
  wire is_lo   = (pwm_cmd == CMD_LOW);
  wire forced  = !supply_ok || !dis_n || !(is_hi || is_lo);
  wire cmd_chg = (pwm_cmd != prev_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cmd <= CMD_PARK;
      gh_q     <= 1'b0;
      gl_q     <= 1'b0;
      dcnt     <= '0;
      tcnt     <= '0;
    end else begin
      prev_cmd <= pwm_cmd;
      if (forced) begin
        gh_q <= 1'b0;
        gl_q <= 1'b0;
        dcnt <= '0;
        tcnt <= '0;
      end else if (is_hi) begin
        gl_q <= 1'b0;
        tcnt <= '0;
        if (cmd_chg) dcnt <= '0;
        else if (!gh_q) begin
          if (gl_q || !low_gate_below) dcnt <= '0;
          else if (dcnt >= dead_on)    gh_q <= 1'b1;
          else                         dcnt <= dcnt + 1'b1;
        end
      end else begin
        gh_q <= 1'b0;
        if (!skip_n || cmd_chg || gh_q) begin
          if (!skip_n) gl_q <= 1'b0;
          dcnt <= '0;
          tcnt <= '0;
        end else if (!gl_q) begin
          if ((sw_node_below && dcnt >= dead_off) || (hs_vgs_below && tcnt >= timeout))
            gl_q <= 1'b1;
          dcnt <= sw_node_below ? dcnt + 1'b1 : '0;
          tcnt <= hs_vgs_below  ? tcnt + 1'b1 : '0;
        end
      end
    end
  end

  assign gh_en = gh_q;
  assign gl_en = gl_q;

  // R10
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh_en && gl_en));

  // R1
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!gh_en && !gl_en));

  // R2
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |=> (!gh_en && !gl_en));

  // R3
  park_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_cmd[1] |=> (!gh_en && !gl_en));

  // R5
  skip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_n |=> !gl_en);

  // R6
  gh_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_en) |-> ($past(low_gate_below) && !$past(gl_en) && $past(pwm_cmd) == CMD_HIGH));

  // R7
  gl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_en) |-> ($past(skip_n) && !$past(gh_en) && $past(pwm_cmd) == CMD_LOW));
endmodule

// File: tb/deadtime_sequencer_bench.sv
module deadtime_sequencer_bench;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwm_cmd = 2'b10;
  logic skip_n = 1'b1, dis_n = 1'b1, supply_ok = 1'b1;
  logic low_gate_below = 1'b1, sw_node_below = 1'b1, hs_vgs_below = 1'b1;
  logic [CW-1:0] dead_on = 8'd2, dead_off = 8'd2, timeout = 8'd9;
  logic gh_en, gl_en;

  int checks = 0, errors = 0, overlap = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  deadtime_sequencer #(.CW(CW)) u_deadtime_sequencer (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .skip_n(skip_n), .dis_n(dis_n),
    .supply_ok(supply_ok), .low_gate_below(low_gate_below), .sw_node_below(sw_node_below),
    .hs_vgs_below(hs_vgs_below), .dead_on(dead_on), .dead_off(dead_off), .timeout(timeout),
    .gh_en(gh_en), .gl_en(gl_en));

  always @(negedge clk) if (rst_n && gh_en && gl_en) overlap++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {supply_ok, dis_n, skip_n, pwm_cmd[1:0], exp_gh, exp_gl}
  localparam int NV = 14;
  localparam logic [6:0] VEC [NV] = '{
    7'b1110110, 7'b1110001, 7'b1111000, 7'b1110001, 7'b1111100,
    7'b1100110, 7'b1100000, 7'b1110001, 7'b1010000, 7'b1010100,
    7'b0110100, 7'b1110110, 7'b0110000, 7'b1100110 };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_rise(input bit high_side, output int n);
    n = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if ((high_side ? gh_en : gl_en) && n == 0) n = k;
    end
  endtask

  task automatic settle(input logic [1:0] c);
    pwm_cmd = c; skip_n = 1'b1; dis_n = 1'b1; supply_ok = 1'b1;
    low_gate_below = 1'b1; sw_node_below = 1'b1; hs_vgs_below = 1'b1;
    edges(30);
  endtask

  initial begin
    int n;
    edges(2);
    check("R3", "reset gh", int'(gh_en), 0);
    check("R3", "reset gl", int'(gl_en), 0);
    rst_n = 1'b1;
    edges(2);

    for (int i = 0; i < NV; i++) begin
      string req;
      {supply_ok, dis_n, skip_n, pwm_cmd} = VEC[i][6:2];
      edges(30);
      if (!VEC[i][6]) req = "R1";
      else if (!VEC[i][5]) req = "R2";
      else if (VEC[i][3]) req = "R3";
      else if (!VEC[i][4]) req = "R5";
      else req = "R4";
      check(req, $sformatf("vec %0d gh", i), int'(gh_en), int'(VEC[i][1]));
      check(req, $sformatf("vec %0d gl", i), int'(gl_en), int'(VEC[i][0]));
    end

    // R6 exact dead-on timing, gated by the low-gate flag
    dead_on = 8'd3; settle(2'b00);
    low_gate_below = 1'b0; pwm_cmd = 2'b01;
    edges(1);
    check("R6", "gl cleared on change edge", int'(gl_en), 0);
    check("R6", "gh low on change edge", int'(gh_en), 0);
    edges(19);
    check("R6", "gh held off without gate flag", int'(gh_en), 0);
    settle(2'b00);
    pwm_cmd = 2'b01;
    count_rise(1'b1, n);
    check("R6", "gh rise edge", n, 5);

    // R7 dead-off timing
    dead_off = 8'd4; settle(2'b01);
    pwm_cmd = 2'b00;
    edges(1);
    check("R7", "gh cleared on change edge", int'(gh_en), 0);
    count_rise(1'b0, n);
    check("R7", "gl rise edge", n + 1, 6);

    // R8 backup timeout and no-flag case
    timeout = 8'd6; dead_off = 8'd2; settle(2'b01);
    sw_node_below = 1'b0; pwm_cmd = 2'b00;
    count_rise(1'b0, n);
    check("R8", "timeout gl rise edge", n, 8);
    settle(2'b01);
    sw_node_below = 1'b0; hs_vgs_below = 1'b0; pwm_cmd = 2'b00;
    edges(40);
    check("R8", "gl stays off with no flag", int'(gl_en), 0);

    // R9 exits from tri-state
    settle(2'b10); pwm_cmd = 2'b00;
    count_rise(1'b0, n);
    check("R9", "park to LOW gl edge", n, 4);
    dead_on = 8'd5; settle(2'b11); pwm_cmd = 2'b01;
    count_rise(1'b1, n);
    check("R9", "park to HIGH gh edge", n, 7);

    // R11 cancel pending turn-on
    settle(2'b00); pwm_cmd = 2'b01;
    edges(3);
    pwm_cmd = 2'b00;
    count_rise(1'b0, n);
    check("R11", "gl back after cancel", n, 4);
    check("R11", "gh never rose", int'(gh_en), 0);
    pwm_cmd = 2'b01;
    count_rise(1'b1, n);
    check("R11", "gh counts from new change", n, 7);

    // R2 / R1 take effect after one edge
    settle(2'b01); dis_n = 1'b0;
    edges(1);
    check("R2", "gh off one edge after disable", int'(gh_en), 0);
    settle(2'b00); supply_ok = 1'b0;
    edges(1);
    check("R1", "gl off one edge after supply loss", int'(gl_en), 0);
    settle(2'b00); skip_n = 1'b0;
    edges(1);
    check("R5", "gl off one edge after skip", int'(gl_en), 0);

    check("R10", "overlap cycles", overlap, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule